// File: doc/BRIEF.md
# PWM Fault Guard

The PWM fault guard sits between four already-routed PWM channels and the pins. It watches three fault sources:
- an external interrupt line that signals a fault when it is low;
- two comparator outputs that signal a fault when they are high.

A 3-bit mask chooses which of these sources count. When a selected source signals a fault, the block forces every enabled channel into a programmed safe state. It does this straight from the raw input level, without waiting for a clock edge. Channels 0 and 2 share one safe-state field and channels 1 and 3 share another. A safe state drives the pin low, drives it high, or releases it to high impedance.

A status bit reports the fault to firmware. The status logic uses synchronised copies of the fault inputs. With automatic restart off, the bit stays set until firmware clears it. A clear has no effect while the synchronised fault is still present. With automatic restart on, hardware clears the bit once the fault has gone. In both cases the outputs stay in the safe state until the next period-start strobe after the status has cleared. The PWM channels therefore restart only with a whole pulse.

Top module: `pwm_fault_guard`

## Requirements
- R1: `cfg_src_sel` is a mask. Bit 0 enables the low level of `ext_int_n` as a fault, bit 1 enables the high level of `cmp_a`, and bit 2 enables the high level of `cmp_b`. A source whose bit is 0 has no effect on the pins or on the status.
- R2: After reset, `sts_fault` is 0 and the pins pass through. A selected fault sets `sts_fault` on the third rising edge after it appears, because the fault passes through a two-stage synchroniser first.
- R3: With `cfg_restart_en` at 0, `sts_fault` stays at 1 after the fault goes away. It clears only on a clock edge where `sts_clr` is 1.
- R4: A `sts_clr` pulse given while the synchronised fault is still active leaves `sts_fault` at 1.
- R5: The override follows the raw fault level combinationally. The pins take the safe state before any clock edge, while `sts_fault` is still 0.
- R6: Safe-state encoding is 00 = drive 0, 01 = drive 1, 1x = high impedance (`pin_oe` = 0, `pin_out` = 0). `cfg_ac_state` controls pins 0 and 2; `cfg_bd_state` controls pins 1 and 3.
- R7: With `cfg_restart_en` at 1, `sts_fault` clears by itself on the third rising edge after the fault goes away.
- R8: After `sts_fault` has cleared, the pins remain overridden. They are released on the edge where `period_start` is 1 and `sts_fault` is already 0. A period start seen while `sts_fault` is 1 does not release them.
- R9: The override applies only to pins whose `pwm_oe_in` bit is 1. A pin whose enable is 0 keeps `pin_oe` = 0 and `pin_out` = `pwm_in` even during a fault.
- R10: With no fault and no pending release, `pin_out` equals `pwm_in` and `pin_oe` equals `pwm_oe_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_int_n | input | 1 | External fault line, fault when low |
| cmp_a | input | 1 | Comparator A output, fault when high |
| cmp_b | input | 1 | Comparator B output, fault when high |
| period_start | input | 1 | One-cycle strobe at each PWM period start |
| cfg_src_sel | input | 3 | Fault source mask |
| cfg_restart_en | input | 1 | Automatic restart enable |
| cfg_ac_state | input | 2 | Safe state for pins 0 and 2 |
| cfg_bd_state | input | 2 | Safe state for pins 1 and 3 |
| sts_clr | input | 1 | Firmware clear of the status bit |
| sts_fault | output | 1 | Shutdown event status |
| pwm_in | input | 4 | Routed PWM data per pin |
| pwm_oe_in | input | 4 | Routed output enable per pin |
| pin_out | output | 4 | Pin data |
| pin_oe | output | 4 | Pin output enable |

## Verification
The assertions assume the following about the inputs:
- `period_start` is a single-cycle strobe;
- the configuration fields change only while no fault is pending;
- fault inputs are held for at least three clock cycles, so the synchronised copy sees every event that the raw path acts on.

The stimulus changes inputs only just after a rising edge and keeps every fault level for several cycles. It also changes the masks and safe-state fields only while the status is clear or while the fault is steady.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  localparam int N_SRC = 3;

  typedef enum logic [1:0] {
    SAFE_LOW  = 2'b00,
    SAFE_HIGH = 2'b01,
    SAFE_TRI  = 2'b10
  } safe_state_e;

  // Normalise the sources to active-high and apply the enable mask.
  function automatic logic [N_SRC-1:0] src_levels(
    input logic [N_SRC-1:0] sel,
    input logic             ext_n,
    input logic             ca,
    input logic             cb
  );
    return {cb, ca, ~ext_n} & sel;
  endfunction

  // Returns {oe, data} for a safe-state code; bit 1 set means high impedance.
  function automatic logic [1:0] safe_drive(input logic [1:0] state);
    logic [1:0] r;
    if (state[1])                 r = 2'b00;
    else if (state == SAFE_HIGH)  r = 2'b11;
    else                          r = 2'b10;
    return r;
  endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfg_status.sv
module pfg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_fault,
  input  logic restart_en,
  input  logic clr,
  input  logic period_start,
  output logic status,
  output logic hold
);
  logic status_d, hold_d;

  always_comb begin
    status_d = sync_fault | (status & ~(restart_en | clr));
    hold_d   = sync_fault | (hold & ~(period_start & ~status));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      hold   <= 1'b0;
    end else begin
      status <= status_d;
      hold   <= hold_d;
    end
  end
endmodule

// File: rtl/pfg_pin.sv
module pfg_pin
  import pfg_pkg::*;
(
  input  logic       override,
  input  logic [1:0] state,
  input  logic       d_in,
  input  logic       oe_in,
  output logic       d_out,
  output logic       oe_out
);
  logic [1:0] drv;

  always_comb begin
    drv = safe_drive(state);
    if (override && oe_in) begin
      d_out  = drv[0];
      oe_out = drv[1];
    end else begin
      d_out  = d_in;
      oe_out = oe_in;
    end
  end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pfg_pkg::*;
#(
  parameter int N_PINS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_int_n,
  input  logic              cmp_a,
  input  logic              cmp_b,
  input  logic              period_start,
  input  logic [N_SRC-1:0]  cfg_src_sel,
  input  logic              cfg_restart_en,
  input  logic [1:0]        cfg_ac_state,
  input  logic [1:0]        cfg_bd_state,
  input  logic              sts_clr,
  output logic              sts_fault,
  input  logic [N_PINS-1:0] pwm_in,
  input  logic [N_PINS-1:0] pwm_oe_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe
);
  localparam int N_PAIRS = 2;

  logic [N_SRC-1:0] raw_vec, sync_vec;
  logic raw_fault, sync_fault, hold, override;

  assign raw_vec   = src_levels(cfg_src_sel, ext_int_n, cmp_a, cmp_b);
  assign raw_fault = |raw_vec;

  pfg_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (raw_vec), .q (sync_vec)
  );
  assign sync_fault = |sync_vec;

  pfg_status u_status (
    .clk (clk), .rst_n (rst_n), .sync_fault (sync_fault),
    .restart_en (cfg_restart_en), .clr (sts_clr),
    .period_start (period_start), .status (sts_fault), .hold (hold)
  );

  // Raw level acts directly; the registered hold keeps the pins safe until the period boundary.
  assign override = raw_fault | hold;

  genvar i;
  generate
    for (i = 0; i < N_PINS; i++) begin : g_pin
      localparam int PAIR = i % N_PAIRS;
      logic [1:0] st;
      if (PAIR == 0) begin : g_ac
        assign st = cfg_ac_state;
      end else begin : g_bd
        assign st = cfg_bd_state;
      end
      pfg_pin u_pin (
        .override (override), .state (st),
        .d_in (pwm_in[i]), .oe_in (pwm_oe_in[i]),
        .d_out (pin_out[i]), .oe_out (pin_oe[i])
      );
    end
  endgenerate
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int N_PINS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              raw_fault,
  input logic              sync_fault,
  input logic              hold,
  input logic              sts_fault,
  input logic              sts_clr,
  input logic              cfg_restart_en,
  input logic              period_start,
  input logic [1:0]        cfg_ac_state,
  input logic [1:0]        cfg_bd_state,
  input logic [N_PINS-1:0] pwm_in,
  input logic [N_PINS-1:0] pwm_oe_in,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] pin_oe
);
  AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fault |=> sts_fault); // R2

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_fault && !cfg_restart_en && !sts_clr) |=> sts_fault); // R3

  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && sync_fault) |=> sts_fault); // R4

  AST_ASYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_fault && pwm_oe_in[0] && cfg_ac_state == 2'b00) |-> (pin_oe[0] && !pin_out[0])); // R5

  AST_TRI_BD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_fault && pwm_oe_in[1] && cfg_bd_state[1]) |-> !pin_oe[1]); // R6

  AST_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_fault && cfg_restart_en && !sync_fault) |=> !sts_fault); // R7

  AST_RESUME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> ($past(period_start) && !$past(sts_fault))); // R8

  AST_DISABLED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_oe_in[N_PINS-1] |-> (!pin_oe[N_PINS-1] && pin_out[N_PINS-1] == pwm_in[N_PINS-1])); // R9

  AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_fault && !hold) |-> (pin_out == pwm_in && pin_oe == pwm_oe_in)); // R10
endmodule

bind pwm_fault_guard pfg_checker #(.N_PINS(N_PINS)) u_chk (
  .clk (clk), .rst_n (rst_n), .raw_fault (raw_fault), .sync_fault (sync_fault),
  .hold (hold), .sts_fault (sts_fault), .sts_clr (sts_clr),
  .cfg_restart_en (cfg_restart_en), .period_start (period_start),
  .cfg_ac_state (cfg_ac_state), .cfg_bd_state (cfg_bd_state),
  .pwm_in (pwm_in), .pwm_oe_in (pwm_oe_in), .pin_out (pin_out), .pin_oe (pin_oe)
);

// File: tb/sim_pwm_fault_guard.sv
`timescale 1ns/1ps
module sim_pwm_fault_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_int_n = 1'b1, cmp_a = 1'b0, cmp_b = 1'b0, period_start = 1'b0;
  logic [2:0] cfg_src_sel = 3'b111;
  logic cfg_restart_en = 1'b0;
  logic [1:0] cfg_ac_state = 2'b00, cfg_bd_state = 2'b01;
  logic sts_clr = 1'b0;
  logic sts_fault;
  logic [3:0] pwm_in = 4'b1010, pwm_oe_in = 4'b1111;
  logic [3:0] pin_out, pin_oe;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [8:0] q_exp[$];
  string      q_req[$];

  always #5 clk = ~clk;

  pwm_fault_guard u0 (
    .clk (clk), .rst_n (rst_n), .ext_int_n (ext_int_n), .cmp_a (cmp_a), .cmp_b (cmp_b),
    .period_start (period_start), .cfg_src_sel (cfg_src_sel), .cfg_restart_en (cfg_restart_en),
    .cfg_ac_state (cfg_ac_state), .cfg_bd_state (cfg_bd_state), .sts_clr (sts_clr),
    .sts_fault (sts_fault), .pwm_in (pwm_in), .pwm_oe_in (pwm_oe_in),
    .pin_out (pin_out), .pin_oe (pin_oe)
  );

  // Expected pins from the requirement text: {oe[3:0], out[3:0]}
  function automatic logic [7:0] model(input logic ovr);
    logic [3:0] o, e;
    for (int p = 0; p < 4; p++) begin
      logic [1:0] st;
      st = (p == 0 || p == 2) ? cfg_ac_state : cfg_bd_state;
      if (ovr && pwm_oe_in[p]) begin
        case (st)
          2'b00:   begin o[p] = 1'b0; e[p] = 1'b1; end
          2'b01:   begin o[p] = 1'b1; e[p] = 1'b1; end
          default: begin o[p] = 1'b0; e[p] = 1'b0; end
        endcase
      end else begin
        o[p] = pwm_in[p];
        e[p] = pwm_oe_in[p];
      end
    end
    return {e, o};
  endfunction

  task automatic expect_pins(input string req, input logic ovr, input logic sts);
    q_exp.push_back({sts, model(ovr)});
    q_req.push_back(req);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q_exp.size() > 0) begin
      logic [8:0] e;
      string r;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      checks++;
      if ({sts_fault, pin_oe, pin_out} !== e) begin
        errors++;
        $display("FAIL %s: got sts=%b oe=%b out=%b expected sts=%b oe=%b out=%b",
                 r, sts_fault, pin_oe, pin_out, e[8], e[7:4], e[3:0]);
      end
    end
  end

  initial begin
    #3;
    expect_pins("R2 reset", 1'b0, 1'b0);
    step(2);
    rst_n = 1'b1;
    step(1);
    expect_pins("R10 pass", 1'b0, 1'b0);
    step(1);
    pwm_in = 4'b0101; pwm_oe_in = 4'b1110;
    expect_pins("R10 pass pattern2", 1'b0, 1'b0);
    step(1);
    pwm_oe_in = 4'b1111;

    // R1: masked external source ignored
    cfg_src_sel = 3'b110; ext_int_n = 1'b0;
    expect_pins("R1 masked ext immediate", 1'b0, 1'b0);
    step(4);
    expect_pins("R1 masked ext later", 1'b0, 1'b0);
    step(1);
    ext_int_n = 1'b1; cfg_src_sel = 3'b111;
    step(1);

    // R5: asynchronous override from cmp_a
    cmp_a = 1'b1;
    expect_pins("R5 async override", 1'b1, 1'b0);
    step(1);
    expect_pins("R2 status not yet after 1 edge", 1'b1, 1'b0);
    step(1);
    expect_pins("R2 status not yet after 2 edges", 1'b1, 1'b0);
    step(1);
    expect_pins("R2 status set after 3 edges", 1'b1, 1'b1);
    step(1);
    cfg_bd_state = 2'b10;
    expect_pins("R6 tri on B/D pair", 1'b1, 1'b1);
    step(1);
    cfg_ac_state = 2'b01; cfg_bd_state = 2'b00;
    expect_pins("R6 drive1 on A/C drive0 on B/D", 1'b1, 1'b1);
    step(1);

    // R4: clear while fault active
    sts_clr = 1'b1;
    step(1);
    sts_clr = 1'b0;
    expect_pins("R4 clear blocked", 1'b1, 1'b1);
    step(1);

    // R3: sticky with restart off
    cmp_a = 1'b0;
    step(6);
    expect_pins("R3 sticky after fault gone", 1'b1, 1'b1);
    step(1);
    period_start = 1'b1;
    step(1);
    period_start = 1'b0;
    expect_pins("R8 period start while status set", 1'b1, 1'b1);
    step(1);
    sts_clr = 1'b1;
    step(1);
    sts_clr = 1'b0;
    expect_pins("R3 cleared by firmware", 1'b1, 1'b0);
    step(2);
    expect_pins("R8 held until period start", 1'b1, 1'b0);
    step(1);
    period_start = 1'b1;
    step(1);
    period_start = 1'b0;
    expect_pins("R8 released at period start", 1'b0, 1'b0);
    step(1);

    // R7 and R9: cmp_b with restart on, partial enables
    cfg_restart_en = 1'b1; cfg_src_sel = 3'b100; pwm_oe_in = 4'b0011;
    cmp_b = 1'b1;
    expect_pins("R9 disabled pins untouched", 1'b1, 1'b0);
    step(4);
    expect_pins("R2 status set by cmp_b", 1'b1, 1'b1);
    step(1);
    cmp_b = 1'b0;
    step(2);
    expect_pins("R7 still set after 2 edges", 1'b1, 1'b1);
    step(1);
    expect_pins("R7 auto cleared after 3 edges", 1'b1, 1'b0);
    step(1);
    period_start = 1'b1;
    step(1);
    period_start = 1'b0;
    expect_pins("R8 resume after auto restart", 1'b0, 1'b0);
    step(1);

    // R1: external source selected alone
    pwm_oe_in = 4'b1111; cfg_src_sel = 3'b001; cmp_a = 1'b1;
    expect_pins("R1 unselected cmp_a ignored", 1'b0, 1'b0);
    step(1);
    cmp_a = 1'b0; ext_int_n = 1'b0;
    expect_pins("R1 ext low selected", 1'b1, 1'b0);
    step(4);
    expect_pins("R1 ext status", 1'b1, 1'b1);
    step(1);
    ext_int_n = 1'b1;
    step(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule